// File: doc/BRIEF.md
# UART Interrupt Status and Mask Aggregator

This block gathers every interrupt source of a serial port into one level interrupt line. Five conditions come live from the receive and transmit queues. Five more come as single-cycle event pulses from the serial engines. Each source owns one bit of a sticky status register, and software clears those bits by writing ones. A mask register decides which sticky bits may raise the interrupt line. Software cannot write the mask directly. It changes the mask through a set-only enable port and a clear-only disable port.

The bus decode lives outside this block. It presents a 2-bit register select, a write strobe and the write data, and it receives read data one cycle after it drives a read select. Select codes: 0 is the mask (read-only), 1 is mask-enable, 2 is mask-disable and 3 is the sticky status. Bit map of both mask and status: bit0 receive trigger level reached, bit1 receive queue empty, bit2 receive queue full, bit3 transmit queue empty, bit4 transmit queue full, bit5 receive overrun, bit6 framing error, bit7 parity error, bit8 receive timeout, bit9 modem status changed.

Top module: `uart_irq_agg`

## Requirements
- R1: After synchronous reset the mask, the sticky status and the interrupt output are all 0.
- R2: A write to select 1 ORs the written data into the mask at the next clock edge.
- R3: A write to select 2 clears from the mask every bit written as 1 and leaves the other bits unchanged.
- R4: A write to select 0 leaves the mask unchanged.
- R5: A live condition input high at a clock edge sets its status bit (bits 0 to 4) at that edge. The bit stays set after the condition drops.
- R6: A one-cycle event pulse sets its status bit (bits 5 to 9) at that edge. The bit stays set after the pulse ends.
- R7: A write to select 3 clears every status bit written as 1 and leaves bits written as 0 unchanged.
- R8: When a status bit is cleared by write and set by a live condition or event in the same cycle, the bit ends up set.
- R9: The interrupt output equals the OR of (mask AND status), registered, so it follows a mask or status change one clock edge later.
- R10: Bits 31 to 10 of the mask and the status read as 0. Writing ones to them has no effect.
- R11: Read data is registered and shows the register picked by the select one edge after the select is driven. Selects 1 and 2 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_sel | input | 2 | Write register select (0 mask, 1 enable, 2 disable, 3 status) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select, same encoding |
| rd_data | output | 32 | Registered read data |
| live_cond | input | 5 | Live queue conditions for status bits 0 to 4 |
| evt_pulse | input | 5 | Event pulses for status bits 5 to 9 |
| irq | output | 1 | Level interrupt request |

## Verification
A write, a live condition or an event pulse seen at edge N changes the mask or the status at edge N itself. The interrupt output follows at edge N+1. Read data driven by a select at edge N reflects the register contents just before edge N. The bench therefore drives inputs at falling edges. It reads a register at the edge after the one that changed it, and it samples the interrupt at the falling edge after edge N+1. To check the registered delay, it also samples the interrupt after edge N, where the old value must still show. The set-wins case drives a clearing write and a live or event set in the same cycle.

// File: rtl/uart_irq_agg_pkg.sv
package uart_irq_agg_pkg;

  typedef enum logic [1:0] {
    SEL_MASK    = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_DISABLE = 2'd2,
    SEL_STATUS  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int SRC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] set_bits,
  input  logic [SRC_W-1:0] clr_bits,
  output logic [SRC_W-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= (mask_q | set_bits) & ~clr_bits;
  end

  // R2: enabled bits are present after the edge
  a_r2_enable_sets: assert property (@(posedge clk) disable iff (rst)
    (set_bits != '0) |=> ((mask_q & $past(set_bits)) == $past(set_bits)));

  // R3: disabled bits are absent after the edge
  a_r3_disable_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_bits != '0) |=> ((mask_q & $past(clr_bits)) == '0));

  // R4: without enable or disable the mask holds
  a_r4_mask_holds: assert property (@(posedge clk) disable iff (rst)
    (set_bits == '0 && clr_bits == '0) |=> $stable(mask_q));

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int SRC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] set_bits,
  input  logic [SRC_W-1:0] clr_bits,
  output logic [SRC_W-1:0] status_q
);

  for (genvar b = 0; b < SRC_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)              status_q[b] <= 1'b0;
      else if (set_bits[b]) status_q[b] <= 1'b1;   // set wins over clear
      else if (clr_bits[b]) status_q[b] <= 1'b0;
    end
  end

  // R5 R6 R8: every bit set this cycle is present after the edge
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_bits != '0) |=> ((status_q & $past(set_bits)) == $past(set_bits)));

  // R7: only bits that were cleared or set may change
  a_r7_untouched_hold: assert property (@(posedge clk) disable iff (rst)
    (set_bits == '0 && clr_bits == '0) |=> $stable(status_q));

  // R7: cleared bits without a set drop to 0
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr_bits != '0) |=> ((status_q & $past(clr_bits & ~set_bits)) == '0));

endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
  parameter int SRC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] mask_i,
  input  logic [SRC_W-1:0] status_i,
  output logic             irq_o
);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(mask_i & status_i);
  end

  // R9: interrupt follows masked status one edge later
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_o == ($past(mask_i & status_i) != '0)));

endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
  import uart_irq_agg_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int LIVE_W = 5,
  parameter int EVT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [1:0]        rd_sel,
  output logic [BUS_W-1:0]  rd_data,
  input  logic [LIVE_W-1:0] live_cond,
  input  logic [EVT_W-1:0]  evt_pulse,
  output logic              irq
);

  localparam int SRC_W = LIVE_W + EVT_W;

  logic [SRC_W-1:0] wr_bits;
  logic             unused_wr_hi;
  logic [SRC_W-1:0] mask_set, mask_clr, stat_set, stat_clr;
  logic [SRC_W-1:0] mask_q, status_q;
  reg_sel_e         wsel, rsel;

  assign wsel         = reg_sel_e'(wr_sel);
  assign rsel         = reg_sel_e'(rd_sel);
  assign wr_bits      = wr_data[SRC_W-1:0];
  assign unused_wr_hi = ^wr_data[BUS_W-1:SRC_W];

  always_comb begin
    mask_set = '0;
    mask_clr = '0;
    stat_clr = '0;
    if (wr_en) begin
      case (wsel)
        SEL_ENABLE:  mask_set = wr_bits;
        SEL_DISABLE: mask_clr = wr_bits;
        SEL_STATUS:  stat_clr = wr_bits;
        default:     ;
      endcase
    end
  end

  assign stat_set = {evt_pulse, live_cond};

  irq_mask_reg #(.SRC_W(SRC_W)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .set_bits (mask_set),
    .clr_bits (mask_clr),
    .mask_q   (mask_q)
  );

  irq_status_reg #(.SRC_W(SRC_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .set_bits (stat_set),
    .clr_bits (stat_clr),
    .status_q (status_q)
  );

  irq_line_gen #(.SRC_W(SRC_W)) u_line (
    .clk      (clk),
    .rst      (rst),
    .mask_i   (mask_q),
    .status_i (status_q),
    .irq_o    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rsel)
        SEL_MASK:   rd_data <= {{(BUS_W-SRC_W){1'b0}}, mask_q};
        SEL_STATUS: rd_data <= {{(BUS_W-SRC_W){1'b0}}, status_q};
        default:    rd_data <= '0;
      endcase
    end
  end

  // R10: upper bits of read data stay 0
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (rd_data[BUS_W-1:SRC_W] == '0));

  // R11: enable and disable selects read back 0
  a_r11_wo_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rsel == SEL_ENABLE || rsel == SEL_DISABLE) |=> (rd_data == '0));

endmodule

// File: tb/test_uart_irq_agg.sv
`timescale 1ns/1ps
module test_uart_irq_agg;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic [4:0]  live_cond = '0;
  logic [4:0]  evt_pulse = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_agg i_uart_irq_agg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .live_cond(live_cond),
    .evt_pulse(evt_pulse), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // inputs driven at falling edges
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    rd_sel = sel;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R1 mask", d, 32'h0);
    rd(2'd3, d); check("R1 status", d, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(2'd1, 32'h0000_0005);
    wr(2'd1, 32'h0000_0200);
    rd(2'd0, d); check("R2 enable OR", d, 32'h0000_0205);
    wr(2'd1, 32'hFFFF_FC00);
    rd(2'd0, d); check("R10 mask upper", d, 32'h0000_0205);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(2'd2, 32'h0000_0004);
    rd(2'd0, d); check("R3 disable", d, 32'h0000_0201);
  endtask

  task automatic t_mask_ro();
    logic [31:0] d;
    wr(2'd0, 32'h0000_FFFF);
    rd(2'd0, d); check("R4 mask ro", d, 32'h0000_0201);
    rd(2'd1, d); check("R11 enable reads 0", d, 32'h0);
    rd(2'd2, d); check("R11 disable reads 0", d, 32'h0);
  endtask

  task automatic t_live();
    logic [31:0] d;
    live_cond = 5'b01010;
    tick();
    live_cond = 5'b0;
    tick();
    rd(2'd3, d); check("R5 live sticky", d, 32'h0000_000A);
    check("R9 masked-off irq low", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_event();
    logic [31:0] d;
    evt_pulse = 5'b10000;           // bit9
    @(posedge clk); @(negedge clk);
    evt_pulse = 5'b0;
    check("R9 irq not yet", {31'd0, irq}, 32'h0);
    tick();
    check("R9 irq one edge later", {31'd0, irq}, 32'h1);
    rd(2'd3, d); check("R6 event sticky", d, 32'h0000_020A);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(2'd3, 32'hFFFF_FE08);        // clears 9 and 3, upper ignored
    rd(2'd3, d); check("R7 w1c", d, 32'h0000_0002);
    check("R9 irq dropped", {31'd0, irq}, 32'h0);
    check("R10 status upper", d & 32'hFFFF_FC00, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    live_cond = 5'b00010;           // bit1 held
    evt_pulse = 5'b00010;           // bit6 pulse
    wr(2'd3, 32'h0000_0042);
    live_cond = 5'b0;
    evt_pulse = 5'b0;
    rd(2'd3, d); check("R8 set wins", d, 32'h0000_0042);
    wr(2'd3, 32'h0000_03FF);
    rd(2'd3, d); check("R7 clear all", d, 32'h0);
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    evt_pulse = 5'b11111;
    tick();
    evt_pulse = 5'b0;
    tick();
    check("R9 irq before reset", {31'd0, irq}, 32'h1);
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1 irq after reset", {31'd0, irq}, 32'h0);
    rd(2'd0, d); check("R1 mask after reset", d, 32'h0);
    rd(2'd3, d); check("R1 status after reset", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_disable();
    t_mask_ro();
    t_live();
    t_event();
    t_w1c();
    t_set_wins();
    t_reset_again();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule